// File: doc/BRIEF.md
# Masked Command-Stream Register Writer

This block sits behind a command fetcher and accepts a stream of 32-bit command words on a valid/ready handshake. Every command opens with a parameter word, followed by a header word. The header names a target register and a 4-bit byte-enable mask. It also gives a count of extra parameter words and a flag that picks how those extra words are addressed. Each parameter is merged into an internal register file under the byte-enable mask, using a read-modify-write.

After each completed write, the block raises a one-cycle event carrying the register id and the merged value, so that downstream logic can react to configuration changes. A separate combinational read port exposes every register. A burst either keeps writing the same register or walks upward through consecutive ids. Ids beyond the register file are dropped silently. The stream is held off for exactly one cycle per register write, and no word is ever lost.

Top module: `cmd_reg_writer`

## Requirements
- R1: After reset every register reads zero on the read port, in_ready is high and evt_valid is low; the first accepted word is taken as a parameter word.
- R2: Header mask bit k enables byte lane k (data bits 8k+7..8k, bit 0 the lowest byte). Enabled lanes take the parameter byte and disabled lanes keep the old register byte; a mask of zero leaves the register unchanged.
- R3: The header layout is: register id in bits 15..0, byte mask in bits 19..16, extra count in bits 27..20, group flag in bit 31. The header is the word accepted directly after the parameter word.
- R4: An extra count of N makes the block accept N further parameter words after the header, and write each one with the header's byte mask.
- R5: With the group flag set to 1, extra word i (counting from 0) targets register id+i+1.
- R6: With the group flag clear, every extra word targets the header's register id.
- R7: Each completed write raises evt_valid for exactly one cycle, in the cycle after the write. It carries evt_id and the merged value, and in that same cycle the read port already returns the merged value for that id.
- R8: A write whose target id is 1024 or above changes no register and raises no event; the remaining words of that command are still consumed.
- R9: in_ready is low for exactly one cycle per write, directly after the word that completes it. A word held valid through that cycle is accepted afterwards, and none is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Command word valid |
| in_ready | output | 1 | Block can accept a command word |
| in_word | input | 32 | Command word (parameter or header) |
| rd_addr | input | 10 | Register read address |
| rd_data | output | 32 | Contents of the addressed register |
| evt_valid | output | 1 | One-cycle pulse per completed register write |
| evt_id | output | 16 | Register id of the completed write |
| evt_value | output | 32 | Merged value written |

## Verification
The hardest case to reach from the ports is a grouped burst that starts just below the top of the register file. Its first extra words land in real registers, and the later ones walk past id 1023 and must vanish without an event and without aliasing onto low registers. The stimulus issues such a burst from id 1022 and then reads back registers 0 and 1. Stall behaviour is reached by keeping in_valid asserted back to back across the write cycles, so that every held word must survive a cycle with ready low.

// File: rtl/cmdw_pkg.sv
package cmdw_pkg;
  localparam int WORD_W    = 32;
  localparam int ID_LSB    = 0;
  localparam int ID_W      = 16;
  localparam int MASK_LSB  = 16;
  localparam int MASK_W    = 4;
  localparam int CNT_LSB   = 20;
  localparam int CNT_W     = 8;
  localparam int GRP_BIT   = 31;

  typedef enum logic [1:0] {
    ST_PARAM = 2'd0,
    ST_HDR   = 2'd1,
    ST_WRITE = 2'd2,
    ST_EXTRA = 2'd3
  } parse_state_e;
endpackage

// File: rtl/cmdw_lane_merge.sv
module cmdw_lane_merge #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] new_val,
  input  logic [LANES-1:0]  lane_en,
  output logic [DATA_W-1:0] merged
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged[l*8 +: 8] = lane_en[l] ? new_val[l*8 +: 8] : old_val[l*8 +: 8];
  end
endmodule

// File: rtl/cmdw_regfile.sv
module cmdw_regfile #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] rmw_addr,
  output logic [DATA_W-1:0] rmw_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rmw_data = mem_q[rmw_addr];
  assign rd_data  = mem_q[rd_addr];
endmodule

// File: rtl/cmdw_parser.sv
module cmdw_parser
  import cmdw_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              wr_go,
  output logic [ID_W-1:0]   wr_id,
  output logic [MASK_W-1:0] wr_mask,
  output logic [WORD_W-1:0] wr_data
);
  parse_state_e      state_q, state_d;
  logic [WORD_W-1:0] param_q, param_d;
  logic [ID_W-1:0]   id_q, id_d;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              group_q, group_d;
  logic              take;
  logic              load_en;

  assign in_ready = (state_q != ST_WRITE);
  assign take     = in_valid && in_ready;
  assign load_en  = take || (state_q == ST_WRITE);

  always_comb begin
    state_d = state_q;
    param_d = param_q;
    id_d    = id_q;
    mask_d  = mask_q;
    left_d  = left_q;
    group_d = group_q;
    case (state_q)
      ST_PARAM: begin
        if (take) begin
          param_d = in_word;
          state_d = ST_HDR;
        end
      end
      ST_HDR: begin
        if (take) begin
          id_d    = in_word[ID_LSB +: ID_W];
          mask_d  = in_word[MASK_LSB +: MASK_W];
          left_d  = in_word[CNT_LSB +: CNT_W];
          group_d = in_word[GRP_BIT];
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (left_q == '0) begin
          state_d = ST_PARAM;
        end else begin
          left_d  = left_q - 1'b1;
          id_d    = group_q ? id_q + 1'b1 : id_q;
          state_d = ST_EXTRA;
        end
      end
      ST_EXTRA: begin
        if (take) begin
          param_d = in_word;
          state_d = ST_WRITE;
        end
      end
      default: state_d = ST_PARAM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PARAM;
      param_q <= '0;
      id_q    <= '0;
      mask_q  <= '0;
      left_q  <= '0;
      group_q <= 1'b0;
    end else if (load_en) begin
      state_q <= state_d;
      param_q <= param_d;
      id_q    <= id_d;
      mask_q  <= mask_d;
      left_q  <= left_d;
      group_q <= group_d;
    end
  end

  assign wr_go   = (state_q == ST_WRITE) && (id_q < ID_W'(DEPTH));
  assign wr_id   = id_q;
  assign wr_mask = mask_q;
  assign wr_data = param_q;
endmodule

// File: rtl/cmd_reg_writer.sv
module cmd_reg_writer
  import cmdw_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              evt_valid,
  output logic [ID_W-1:0]   evt_id,
  output logic [WORD_W-1:0] evt_value
);
  logic              wr_go;
  logic [ID_W-1:0]   wr_id;
  logic [MASK_W-1:0] wr_mask;
  logic [WORD_W-1:0] wr_data;
  logic [WORD_W-1:0] old_val;
  logic [WORD_W-1:0] merged;

  logic              evt_valid_q;
  logic [ID_W-1:0]   evt_id_q;
  logic [WORD_W-1:0] evt_value_q;

  cmdw_parser #(.DEPTH(DEPTH)) u_parser (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_word  (in_word),
    .wr_go    (wr_go),
    .wr_id    (wr_id),
    .wr_mask  (wr_mask),
    .wr_data  (wr_data)
  );

  cmdw_regfile #(.DATA_W(WORD_W), .DEPTH(DEPTH)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (wr_go),
    .waddr    (wr_id[ADDR_W-1:0]),
    .wdata    (merged),
    .rmw_addr (wr_id[ADDR_W-1:0]),
    .rmw_data (old_val),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

  cmdw_lane_merge #(.DATA_W(WORD_W)) u_merge (
    .old_val (old_val),
    .new_val (wr_data),
    .lane_en (wr_mask),
    .merged  (merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_valid_q <= 1'b0;
    end else begin
      evt_valid_q <= wr_go;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_id_q    <= '0;
      evt_value_q <= '0;
    end else if (wr_go) begin
      evt_id_q    <= wr_id;
      evt_value_q <= merged;
    end
  end

  assign evt_valid = evt_valid_q;
  assign evt_id    = evt_id_q;
  assign evt_value = evt_value_q;
endmodule

// File: rtl/cmdw_checker.sv
module cmdw_checker #(
  parameter int DEPTH = 1024,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [31:0]       rd_data,
  input logic              evt_valid,
  input logic [15:0]       evt_id,
  input logic [31:0]       evt_value
);
  // R7: event lasts a single cycle
  p_evt_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> !evt_valid);

  // R7: register file already holds the reported value
  p_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && (rd_addr == evt_id[ADDR_W-1:0])) |-> (rd_data == evt_value));

  // R8: no event for an id outside the file
  p_evt_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_id < 16'(DEPTH)));

  // R9: every event follows a stalled cycle
  p_evt_after_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> $past(!in_ready));

  // R9: the stall lasts exactly one cycle
  p_stall_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);
endmodule

bind cmd_reg_writer cmdw_checker #(.DEPTH(DEPTH)) u_cmdw_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .evt_valid (evt_valid),
  .evt_id    (evt_id),
  .evt_value (evt_value)
);

// File: tb/cmd_reg_writer_bench.sv
module cmd_reg_writer_bench;
  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_word;
  logic [9:0]  rd_addr;
  logic [31:0] rd_data;
  logic        evt_valid;
  logic [15:0] evt_id;
  logic [31:0] evt_value;

  int total = 0;
  int bad   = 0;

  logic [31:0] mdl [DEPTH];
  logic [15:0] exp_id_q [$];
  logic [31:0] exp_val_q [$];

  always #5 clk = ~clk;

  cmd_reg_writer #(.DEPTH(DEPTH)) u_cmd_reg_writer (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_word   (in_word),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .evt_valid (evt_valid),
    .evt_id    (evt_id),
    .evt_value (evt_value)
  );

  function automatic logic [31:0] lane_mix(logic [31:0] o, logic [31:0] n, logic [3:0] m);
    logic [31:0] r;
    for (int l = 0; l < 4; l++) r[l*8 +: 8] = m[l] ? n[l*8 +: 8] : o[l*8 +: 8];
    return r;
  endfunction

  // Monitor: pops expected events as the design produces them
  always @(negedge clk) begin
    if (rst_n && evt_valid) begin
      total++;
      if (exp_id_q.size() == 0) begin
        bad++;
        $display("FAIL R8 unexpected event id=%0d value=%h expected none", evt_id, evt_value);
      end else begin
        logic [15:0] eid;
        logic [31:0] ev;
        eid = exp_id_q.pop_front();
        ev  = exp_val_q.pop_front();
        if (evt_id !== eid || evt_value !== ev) begin
          bad++;
          $display("FAIL R7 event id=%0d value=%h expected id=%0d value=%h",
                   evt_id, evt_value, eid, ev);
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one word; called at a falling edge, returns at a falling edge with valid still high
  task automatic put(input logic [31:0] w);
    in_word  = w;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic model_write(input int id, input logic [3:0] m, input logic [31:0] v);
    if (id < DEPTH) begin
      mdl[id] = lane_mix(mdl[id], v, m);
      exp_id_q.push_back(16'(id));
      exp_val_q.push_back(mdl[id]);
    end
  endtask

  // Driver: one full command, expected events pushed to the scoreboard
  task automatic cmd(input int id, input logic [3:0] m, input bit grp, input int n,
                     input logic [31:0] base, input bit gaps);
    logic [31:0] hdr;
    logic [31:0] w;
    hdr = {grp, 3'b000, 8'(n), m, 16'(id)};
    model_write(id, m, base);
    for (int k = 0; k < n; k++) begin
      w = base ^ (32'h1357_9BDF * 32'(k + 1));
      model_write(grp ? id + k + 1 : id, m, w);
    end
    put(base);
    if (gaps) begin in_valid = 1'b0; @(negedge clk); end
    put(hdr);
    for (int k = 0; k < n; k++) begin
      if (gaps) begin in_valid = 1'b0; @(negedge clk); @(negedge clk); end
      put(base ^ (32'h1357_9BDF * 32'(k + 1)));
    end
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input string req, input int a);
    rd_addr = 10'(a);
    #1;
    chk(req, rd_data, mdl[a]);
  endtask

  task automatic run_tests();
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    in_valid = 1'b0;
    in_word  = '0;
    rd_addr  = '0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd("R1 reg0 after reset", 0);
    rd("R1 reg5 after reset", 5);
    rd("R1 reg1023 after reset", 1023);
    chk("R1 in_ready after reset", 32'(in_ready), 32'd1);
    chk("R1 evt_valid after reset", 32'(evt_valid), 32'd0);

    // R2/R3: full mask, then partial lanes, then empty mask
    cmd(3, 4'b1111, 1'b0, 0, 32'hA5A5_1234, 1'b0);
    rd("R3 full-mask write", 3);
    cmd(3, 4'b0101, 1'b0, 0, 32'hFFFF_FFFF, 1'b0);
    chk("R2 lanes 0 and 2", mdl[3], 32'hA5FF_12FF);
    rd("R2 partial mask readback", 3);
    cmd(3, 4'b0000, 1'b0, 0, 32'h0BAD_0BAD, 1'b0);
    rd("R2 zero mask keeps value", 3);
    cmd(7, 4'b1000, 1'b0, 0, 32'h7700_0011, 1'b1);
    rd("R2 top lane only", 7);

    // R4/R5: grouped burst walks ids
    cmd(10, 4'b1111, 1'b1, 3, 32'h1111_0000, 1'b0);
    rd("R5 grouped id 10", 10);
    rd("R5 grouped id 11", 11);
    rd("R5 grouped id 12", 12);
    rd("R4 grouped id 13", 13);
    rd("R4 id 14 untouched", 14);

    // R6: non-grouped burst stays on one id
    cmd(20, 4'b1100, 1'b0, 2, 32'hCAFE_BEEF, 1'b1);
    rd("R6 single-id burst", 20);
    rd("R6 id 21 untouched", 21);

    // R8: out-of-range ids dropped; following command still parsed
    cmd(1024, 4'b1111, 1'b0, 1, 32'hDEAD_DEAD, 1'b0);
    cmd(2000, 4'b1111, 1'b0, 0, 32'hDEAD_0001, 1'b0);
    rd("R8 reg0 not aliased", 0);
    cmd(1022, 4'b1111, 1'b1, 3, 32'h5A5A_5A5A, 1'b0);
    rd("R8 id 1022 written", 1022);
    rd("R8 id 1023 written", 1023);
    rd("R8 reg0 after wrap", 0);
    rd("R8 reg1 after wrap", 1);
    cmd(5, 4'b0011, 1'b0, 0, 32'h0000_ABCD, 1'b0);
    rd("R8 parsing resumes", 5);

    // R9: back-to-back commands with valid held high through stalls
    begin
      logic [31:0] hdr;
      model_write(30, 4'b1111, 32'h3030_3030);
      model_write(31, 4'b1111, 32'h3131_3131);
      model_write(32, 4'b0001, 32'h0000_0032);
      put(32'h3030_3030);
      put({1'b1, 3'b000, 8'd1, 4'b1111, 16'd30});
      put(32'h3131_3131);
      hdr = {1'b0, 3'b000, 8'd0, 4'b0001, 16'd32};
      put(32'h0000_0032);
      put(hdr);
      in_valid = 1'b0;
      repeat (4) @(negedge clk);
    end
    rd("R9 held word 30", 30);
    rd("R9 held word 31", 31);
    rd("R9 held word 32", 32);

    repeat (4) @(negedge clk);
    chk("R7 all expected events seen", 32'(exp_id_q.size()), 32'd0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule